// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive side of an asynchronous serial port. It watches a serial input line at sixteen times the bit rate, finds each start bit, recovers eight data bits (least significant first), an optional parity bit and the stop bit. Every finished character is stored in a 16-entry queue. Three per-character error flags travel with it: framing, parity and line break.

The bit rate comes from a single-cycle strobe, `sample_tick`, which the surrounding logic pulses sixteen times per bit period. Parity checking is set by three static inputs: enable, even/odd select and fixed ("stick") mode. A consumer reads the head of the queue on `rd_word` and removes it by pulsing `rd_pop` for one cycle. A sticky overrun flag, shown in the top bit of `rd_word`, reports characters that were lost because the queue was full.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `q_empty` is 1, `q_full` is 0 and `rd_word` is all zeros.
- R2: A frame made of a low start bit, eight data bits sent least significant first and a high stop bit stores one entry. It appears on `rd_word` with the data in bits 7:0 and bits 11:8 at zero.
- R3: A low pulse on the line that has gone high again by the middle of the would-be start bit (sample 8 of 16) is ignored and stores nothing.
- R4: With `par_en`=1, a parity bit follows the data. With `par_even`=1 the expected bit makes the total count of ones even, and with `par_even`=0 it makes the count odd. A mismatch sets bit 9 of the stored entry. With `par_en`=0, bit 9 is always 0.
- R5: With `par_en`=1 and `par_stick`=1, the expected parity bit is fixed: 0 when `par_even`=1 and 1 when `par_even`=0. A mismatch sets bit 9.
- R6: A frame whose stop bit is sampled as 0, and that is not a break, is stored with bit 8 set. The receiver then waits for the line to go high before it looks for a new start bit.
- R7: If the line stays low through a whole frame time (start, data, parity if enabled, stop), exactly one entry is stored: data 0 with bit 10 set and bits 8 and 9 clear. Nothing more is stored until the line goes high and a new valid start bit arrives.
- R8: The queue holds 16 entries in arrival order. `q_full` is 1 exactly when it holds 16, and `q_empty` is 1 exactly when it holds none. A one-cycle `rd_pop` removes the head. A pop when the queue is empty has no effect.
- R9: If a character completes while the queue is full, that character is discarded, the queue contents stay unchanged, and bit 11 of `rd_word` goes to 1. Bit 11 returns to 0 once the queue has a free entry.
- R10: Bits 10:8 on `rd_word` are the flags of the entry currently at the head of the queue. They change to the next entry's flags when the head is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Strobe pulsed 16 times per bit period |
| rx_line | input | 1 | Serial input line, idle high |
| par_en | input | 1 | A parity bit follows the data |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| par_stick | input | 1 | Expected parity bit is fixed by `par_even` |
| rd_pop | input | 1 | Remove the head entry |
| rd_word | output | 12 | {overrun, break, parity err, framing err, data[7:0]} of the head |
| q_full | output | 1 | Queue holds 16 entries |
| q_empty | output | 1 | Queue holds no entries |

## Verification
A bit counter or phase counter that is off by one shifts the sampling point. The fault shows up on the data bits of the very next entry, or as a framing flag on it, one frame after it happens. A break detector that fires too early, too often, or does not wait for the line to go high shows up right away as extra or missing zero entries behind the break. The queue pointers and the overrun flag are observed at the queue's edges: filling it to 16, forcing one more character in, and draining it. A wrong count shows up as a mis-ordered head, a full flag at the wrong count, or an overrun bit that stays set one cycle after a pop.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              perr;
    logic              ferr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_WAIT_HI
  } rx_state_t;

  // Parity bit the sender should have produced for this character.
  function automatic logic want_parity(logic [CHAR_W-1:0] d, logic even, logic stick);
    if (stick) return ~even;
    return even ? (^d) : ~(^d);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_even,
  input  logic      par_stick,
  output logic      frame_push,
  output rx_entry_t frame_entry
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(CHAR_W);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] TOPB = BW'(CHAR_W - 1);

  rx_state_t         state_q;
  logic [CW-1:0]     phase_q;
  logic [BW-1:0]     bit_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              pbit_q;
  logic              all_low_q;
  logic              perr_now;

  assign perr_now = par_en && (pbit_q != want_parity(shreg_q, par_even, par_stick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= '0;
      bit_q       <= '0;
      shreg_q     <= '0;
      pbit_q      <= 1'b0;
      all_low_q   <= 1'b0;
      frame_push  <= 1'b0;
      frame_entry <= '0;
    end else begin
      frame_push <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tick && !rxd) begin
          state_q <= ST_START;
          phase_q <= '0;
        end
        ST_START: if (tick) begin
          if (phase_q == MID) begin
            phase_q   <= '0;
            bit_q     <= '0;
            all_low_q <= 1'b1;
            state_q   <= rxd ? ST_IDLE : ST_DATA;
          end else phase_q <= phase_q + 1'b1;
        end
        ST_DATA: if (tick) begin
          if (phase_q == LAST) begin
            phase_q   <= '0;
            shreg_q   <= {rxd, shreg_q[CHAR_W-1:1]};
            all_low_q <= all_low_q & ~rxd;
            bit_q     <= bit_q + 1'b1;
            if (bit_q == TOPB) state_q <= par_en ? ST_PAR : ST_STOP;
          end else phase_q <= phase_q + 1'b1;
        end
        ST_PAR: if (tick) begin
          if (phase_q == LAST) begin
            phase_q   <= '0;
            pbit_q    <= rxd;
            all_low_q <= all_low_q & ~rxd;
            state_q   <= ST_STOP;
          end else phase_q <= phase_q + 1'b1;
        end
        ST_STOP: if (tick) begin
          if (phase_q == LAST) begin
            phase_q <= '0;
            if (rxd) begin
              frame_push  <= 1'b1;
              frame_entry <= '{brk: 1'b0, perr: perr_now, ferr: 1'b0, data: shreg_q};
              state_q     <= ST_IDLE;
            end else if (all_low_q) begin
              state_q <= ST_BRK;
            end else begin
              frame_push  <= 1'b1;
              frame_entry <= '{brk: 1'b0, perr: perr_now, ferr: 1'b1, data: shreg_q};
              state_q     <= ST_WAIT_HI;
            end
          end else phase_q <= phase_q + 1'b1;
        end
        ST_BRK: if (tick) begin
          if (rxd) begin
            frame_push  <= 1'b1;
            frame_entry <= '{brk: 1'b0, perr: perr_now, ferr: 1'b1, data: shreg_q};
            state_q     <= ST_IDLE;
          end else if (phase_q == MID) begin
            frame_push  <= 1'b1;
            frame_entry <= '{brk: 1'b1, perr: 1'b0, ferr: 1'b0, data: '0};
            state_q     <= ST_WAIT_HI;
          end else phase_q <= phase_q + 1'b1;
        end
        ST_WAIT_HI: if (rxd) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [AW:0]      count_q;
  logic             do_push, do_pop;

  assign full    = (count_q == (AW+1)'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wptr_q] <= din;
        wptr_q        <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      end
      if (do_pop) rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_tick,
  input  logic        rx_line,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        rd_pop,
  output logic [11:0] rd_word,
  output logic        q_full,
  output logic        q_empty
);
  logic               rxd_sync;
  logic               frame_push;
  rx_entry_t          frame_entry;
  logic [ENTRY_W-1:0] head_bits;
  logic               ovr_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rxd_sync)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rxd(rxd_sync),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .frame_push(frame_push), .frame_entry(frame_entry)
  );

  uart_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(frame_push), .din(frame_entry),
    .pop(rd_pop), .head(head_bits), .full(q_full), .empty(q_empty)
  );

  // Sticky loss flag: set by a rejected character, held only while still full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= (frame_push && q_full) || (ovr_q && q_full);
  end

  assign rd_word = {ovr_q, head_bits};
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_push,
  input logic [10:0] frame_entry,
  input logic        par_en,
  input logic        q_full,
  input logic        q_empty,
  input logic        ovr_q,
  input logic        rd_pop
);
  a_r8_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  a_r8_pop_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    q_full && rd_pop |=> !q_full);

  a_r9_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_push && q_full |=> ovr_q);

  a_r9_discard_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    frame_push && q_full && !rd_pop |=> q_full);

  a_r9_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !q_full |=> !ovr_q);

  a_r7_break_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_push && frame_entry[10] |-> (frame_entry[7:0] == 8'h00) && !frame_entry[8] && !frame_entry[9]);

  a_r4_no_perr_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    frame_push && !par_en |-> !frame_entry[9]);
endmodule

bind uart_rx_core uart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_push(frame_push), .frame_entry(frame_entry),
  .par_en(par_en), .q_full(q_full), .q_empty(q_empty), .ovr_q(ovr_q), .rd_pop(rd_pop)
);

// File: tb/uart_rx_core_tb.sv
`timescale 1ns/1ps
module uart_rx_core_tb;
  localparam int TICK_DIV = 4;
  localparam int BITCLK   = 16 * TICK_DIV;

  logic clk = 1'b0, rst_n = 1'b0, sample_tick = 1'b0, rx_line = 1'b1;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, rd_pop = 1'b0;
  logic [11:0] rd_word;
  logic q_full, q_empty;
  int errors = 0, checks = 0, tcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
    sample_tick <= (tcnt == TICK_DIV-1);
  end

  uart_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .rd_pop(rd_pop),
    .rd_word(rd_word), .q_full(q_full), .q_empty(q_empty)
  );

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  function automatic logic bench_par(input logic [7:0] d, input bit even);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return even ? logic'(ones % 2) : logic'((ones + 1) % 2);
  endfunction

  task automatic line_for(input logic v, input int nclk);
    rx_line = v;
    repeat (nclk) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit with_par, input logic pbit, input logic stopb);
    @(negedge clk);
    line_for(1'b0, BITCLK);
    for (int i = 0; i < 8; i++) line_for(d[i], BITCLK);
    if (with_par) line_for(pbit, BITCLK);
    line_for(stopb, BITCLK);
    line_for(1'b1, 2*BITCLK);
    @(negedge clk);
  endtask

  task automatic pop_expect(input logic [11:0] exp, input string req);
    @(negedge clk);
    check(!q_empty && rd_word == exp, req, rd_word, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    check(q_empty, req, {11'd0, q_empty}, 12'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(q_empty && !q_full && rd_word == 12'h000, "R1", rd_word, 12'h000);
  endtask

  task automatic t_basic;
    send(8'hA5, 0, 0, 1);
    send(8'h3C, 0, 0, 1);
    pop_expect(12'h0A5, "R2");
    pop_expect(12'h03C, "R2");
    expect_empty("R2");
  endtask

  task automatic t_glitch;
    @(negedge clk);
    line_for(1'b0, 3*TICK_DIV);
    line_for(1'b1, 3*BITCLK);
    expect_empty("R3");
    send(8'h81, 0, 0, 1);
    pop_expect(12'h081, "R3");
  endtask

  task automatic t_parity;
    par_en = 1; par_even = 1; par_stick = 0;
    send(8'h03, 1, bench_par(8'h03, 1), 1);
    send(8'h03, 1, ~bench_par(8'h03, 1), 1);
    par_even = 0;
    send(8'h07, 1, ~bench_par(8'h07, 0), 1);
    send(8'h07, 1, bench_par(8'h07, 0), 1);
    // R10: flags follow the head entry as it changes
    pop_expect(12'h003, "R4 R10");
    pop_expect(12'h203, "R4 R10");
    pop_expect(12'h207, "R4 R10");
    pop_expect(12'h007, "R4 R10");
  endtask

  task automatic t_stick;
    par_en = 1; par_stick = 1; par_even = 1;
    send(8'hFF, 1, 1'b0, 1);
    send(8'hFF, 1, 1'b1, 1);
    par_even = 0;
    send(8'h01, 1, 1'b1, 1);
    send(8'h01, 1, 1'b0, 1);
    pop_expect(12'h0FF, "R5");
    pop_expect(12'h2FF, "R5");
    pop_expect(12'h001, "R5");
    pop_expect(12'h201, "R5");
    par_en = 0; par_stick = 0;
  endtask

  task automatic t_framing;
    send(8'h55, 0, 0, 0);
    pop_expect(12'h155, "R6");
    expect_empty("R6");
    send(8'h12, 0, 0, 1);
    pop_expect(12'h012, "R6");
  endtask

  task automatic t_break;
    @(negedge clk);
    line_for(1'b0, 20*BITCLK);
    line_for(1'b1, 2*BITCLK);
    pop_expect(12'h400, "R7");
    expect_empty("R7");
    send(8'h5A, 0, 0, 1);
    pop_expect(12'h05A, "R7");
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 16; i++) begin
      send(8'(8'h10 + i), 0, 0, 1);
      if (i == 14) check(!q_full, "R8", {11'd0, q_full}, 12'd0);
    end
    check(q_full && !q_empty, "R8", {10'd0, q_full, q_empty}, 12'h002);
    send(8'hEE, 0, 0, 1);
    check(q_full && rd_word == 12'h810, "R9", rd_word, 12'h810);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
    check(rd_word == 12'h011 && !q_full, "R9", rd_word, 12'h011);
    for (int i = 1; i < 16; i++) pop_expect(12'(8'h10 + i), "R8");
    expect_empty("R8");
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
    check(q_empty && !q_full && rd_word == 12'h000, "R8", rd_word, 12'h000);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8 * TICK_DIV) @(posedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_parity();
    t_stick();
    t_framing();
    t_break();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule